// File: doc/BRIEF.md
# SRAM Page Write Guard

This block sits on the write port of a small tightly coupled SRAM that is divided into 1 KB pages. It holds a page protection register with one bit per page, up to sixteen. Software may raise a bit to lock its page against writes. No software write can lower a bit again; only a system reset returns the register to all zeros. The number of implemented pages is a parameter (4, 8 or 16). Protection bits at or above that count are not stored and have no effect.

Every SRAM access passes through the guard. A write that targets a locked page reaches the array with its write enable low and all byte strobes low. Reads, addresses and writes to unlocked pages pass through unchanged. Each suppressed write raises a sticky violation flag. Software clears the flag by writing 1 to it.

Software sees two registers, picked by a one-bit select: the protection register and the violation status register. Reads of either return zero in every bit that is not implemented.

Top module: `sram_page_guard`

## Requirements
- R1: After reset, the protection register reads 0, the violation flag is 0, and every page accepts writes.
- R2: A config write with select 0 sets each protection bit whose write-data bit is 1. The lock applies from the SRAM cycle after the config write's clock edge. A write presented in the same cycle as the config write still passes.
- R3: Writing 0 to a set protection bit leaves it set. New 1s are ORed onto the bits already held.
- R4: Data bits 31:16 of the protection register and bits 31:1 of the status register read as 0, whatever was written to them.
- R5: Protection bits at index PAGES and above are not stored. They read 0, and writes to those pages are never blocked.
- R6: The page index is byte-address bits [13:10]. A write to a locked page is driven to the array with write enable 0 and all byte strobes 0. Writes to other pages keep their write enable and strobes.
- R7: The read enable and the address pass to the array unchanged, whether or not the page is locked.
- R8: A suppressed write sets the violation flag (status bit 0) at the next clock edge. The flag then stays set until it is cleared.
- R9: A status write (select 1) with data bit 0 = 1 clears the flag. A status write with data bit 0 = 0 does nothing. When a clear and a suppressed write fall in the same cycle, the flag ends up set.
- R10: Only reset clears protection bits. After reset, previously locked pages accept writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 1 | Register select: 0 = protection, 1 = violation status |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| mem_addr | input | ADDR_W | Byte address from the SRAM master |
| mem_we | input | 1 | Write enable from the master |
| mem_be | input | BE_W | Byte strobes from the master |
| mem_re | input | 1 | Read enable from the master |
| sram_addr | output | ADDR_W | Address to the array |
| sram_we | output | 1 | Gated write enable to the array |
| sram_be | output | BE_W | Gated byte strobes to the array |
| sram_re | output | 1 | Read enable to the array |
| wp_violation | output | 1 | Sticky violation flag |

## Verification
The bench puts a config write and an SRAM write to the same page in one cycle. A guard that applied the lock one cycle early would block that write and raise a false violation. It writes zeros over locked bits, which a design that stores by plain assignment would fail by unlocking pages. It runs with eight pages so that writes to the upper eight pages and to protection bits 15:8 show whether unimplemented bits are stored or acted on. It also lands a flag clear in the same cycle as a blocked write; a design that gave the clear priority would lose that violation.

// File: rtl/sram_wp_pkg.sv
package sram_wp_pkg;

  localparam int MAX_PAGES  = 16;
  localparam int PAGE_LSB   = 10;
  localparam int PAGE_IDX_W = 4;
  localparam int REG_W      = 32;

  typedef enum logic {
    SEL_PROT   = 1'b0,
    SEL_STATUS = 1'b1
  } cfg_sel_e;

  // page number of a byte address inside the SRAM window
  function automatic logic [PAGE_IDX_W-1:0] page_of(input logic [PAGE_LSB+PAGE_IDX_W-1:0] a);
    return a[PAGE_LSB +: PAGE_IDX_W];
  endfunction

  // bits that correspond to implemented pages
  function automatic logic [MAX_PAGES-1:0] impl_mask(input int pages);
    logic [MAX_PAGES-1:0] m;
    for (int i = 0; i < MAX_PAGES; i++) m[i] = (i < pages);
    return m;
  endfunction

endpackage

// File: rtl/wp_prot_reg.sv
module wp_prot_reg
  import sram_wp_pkg::*;
#(
  parameter int PAGES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [MAX_PAGES-1:0] set_bits,
  output logic [MAX_PAGES-1:0] prot_q
);

  localparam logic [MAX_PAGES-1:0] MASK = impl_mask(PAGES);

  for (genvar i = 0; i < MAX_PAGES; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    prot_q[i] <= 1'b0;
        else if (set_en && set_bits[i]) prot_q[i] <= 1'b1;
      end
    end else begin : g_tie
      assign prot_q[i] = 1'b0;
    end
  end

  // R3
  set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((prot_q & $past(prot_q)) == $past(prot_q)));

  // R2
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((prot_q & $past(set_bits) & MASK) == ($past(set_bits) & MASK)));

endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate
  import sram_wp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BE_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MAX_PAGES-1:0] prot,
  input  logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_we,
  input  logic [BE_W-1:0]      mem_be,
  input  logic                 mem_re,
  output logic [ADDR_W-1:0]    sram_addr,
  output logic                 sram_we,
  output logic [BE_W-1:0]      sram_be,
  output logic                 sram_re,
  output logic                 blocked
);

  localparam int WIN_W = PAGE_LSB + PAGE_IDX_W;

  logic [PAGE_IDX_W-1:0] page;
  logic                  page_locked;

  assign page        = page_of(mem_addr[WIN_W-1:0]);
  assign page_locked = prot[page];
  assign blocked     = mem_we && page_locked;

  assign sram_addr = mem_addr;
  assign sram_re   = mem_re;
  assign sram_we   = mem_we && !page_locked;
  assign sram_be   = page_locked ? '0 : mem_be;

  // R6
  no_invented_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> mem_we);

  // R6
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (sram_be == '0 && !sram_we));

endmodule

// File: rtl/wp_viol_flag.sv
module wp_viol_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end

  // R8
  viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);

  // R8
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_evt) |=> flag_q);

  // R9
  viol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !flag_q);

endmodule

// File: rtl/sram_page_guard.sv
module sram_page_guard
  import sram_wp_pkg::*;
#(
  parameter int PAGES  = 16,
  parameter int ADDR_W = 14,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_we,
  input  logic [BE_W-1:0]   mem_be,
  input  logic              mem_re,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_we,
  output logic [BE_W-1:0]   sram_be,
  output logic              sram_re,
  output logic              wp_violation
);

  localparam int WIN_W = PAGE_LSB + PAGE_IDX_W;

  logic [MAX_PAGES-1:0] prot_q;
  logic                 prot_wr;
  logic                 stat_clr;
  logic                 wr_blocked;
  logic                 cfg_hi_unused;

  assign prot_wr       = cfg_we && (cfg_sel == SEL_PROT);
  assign stat_clr      = cfg_we && (cfg_sel == SEL_STATUS) && cfg_wdata[0];
  assign cfg_hi_unused = ^cfg_wdata[31:16];

  wp_prot_reg #(.PAGES(PAGES)) u_prot (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (prot_wr),
    .set_bits (cfg_wdata[MAX_PAGES-1:0]),
    .prot_q   (prot_q)
  );

  wp_write_gate #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .prot      (prot_q),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_re    (mem_re),
    .sram_addr (sram_addr),
    .sram_we   (sram_we),
    .sram_be   (sram_be),
    .sram_re   (sram_re),
    .blocked   (wr_blocked)
  );

  wp_viol_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (wr_blocked),
    .clr_evt (stat_clr),
    .flag_q  (wp_violation)
  );

  always_comb begin
    if (cfg_sel == SEL_PROT) cfg_rdata = {16'h0000, prot_q};
    else                     cfg_rdata = {31'h0, wp_violation};
  end

  // R6
  locked_page_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && prot_q[page_of(mem_addr[WIN_W-1:0])]) |-> !sram_we);

  // R7
  read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_re == mem_re) && (sram_addr == mem_addr));

  // R5
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q & ~impl_mask(PAGES)) == '0);

endmodule

// File: tb/sram_page_guard_tb.sv
module sram_page_guard_tb;

  localparam int PAGES  = 8;
  localparam int ADDR_W = 14;
  localparam int BE_W   = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic              cfg_sel = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic [ADDR_W-1:0] mem_addr = '0;
  logic              mem_we = 1'b0;
  logic [BE_W-1:0]   mem_be = '0;
  logic              mem_re = 1'b0;
  logic [ADDR_W-1:0] sram_addr;
  logic              sram_we;
  logic [BE_W-1:0]   sram_be;
  logic              sram_re;
  logic              wp_violation;

  int total = 0;
  int bad   = 0;
  logic [15:0] exp_prot = '0;

  always #2 clk = ~clk;

  sram_page_guard #(.PAGES(PAGES), .ADDR_W(ADDR_W), .BE_W(BE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_be(mem_be), .mem_re(mem_re), .sram_addr(sram_addr),
    .sram_we(sram_we), .sram_be(sram_be), .sram_re(sram_re),
    .wp_violation(wp_violation)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] paddr(input int page, input int off);
    return ADDR_W'((page << 10) + off);
  endfunction

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd_reg(input logic sel, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  // drive a write for one cycle; returns gated outputs sampled mid-cycle
  task automatic mem_write(input int page, output logic we_o, output logic [BE_W-1:0] be_o);
    @(negedge clk);
    mem_addr = paddr(page, 12); mem_we = 1'b1; mem_be = 4'b1011;
    #1 we_o = sram_we; be_o = sram_be;
    @(negedge clk);
    mem_we = 1'b0; mem_be = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_prot = '0;
  endtask

  task automatic clear_flag();
    cfg_write(1'b1, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic w; logic [BE_W-1:0] b;
    rd_reg(1'b0, d); chk("R1 prot after reset", d, 32'h0);
    chk("R1 flag after reset", {31'h0, wp_violation}, 32'h0);
    mem_write(5, w, b);
    chk("R1 write passes after reset", {31'h0, w}, 32'h1);
  endtask

  task automatic t_set_timing();
    logic w; logic [BE_W-1:0] b; logic [31:0] d;
    // config write and memory write to page 2 in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h0000_0004;
    mem_addr = paddr(2, 0); mem_we = 1'b1; mem_be = 4'hF;
    #1 chk("R2 same-cycle write passes", {31'h0, sram_we}, 32'h1);
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0; mem_we = 1'b0; mem_be = '0;
    exp_prot |= 16'h0004;
    chk("R2 no violation from same-cycle write", {31'h0, wp_violation}, 32'h0);
    mem_write(2, w, b);
    chk("R6 locked page we low", {31'h0, w}, 32'h0);
    chk("R6 locked page strobes low", {28'h0, b}, 32'h0);
    mem_write(3, w, b);
    chk("R6 neighbour page we", {31'h0, w}, 32'h1);
    chk("R6 neighbour page strobes", {28'h0, b}, 32'hB);
    rd_reg(1'b0, d); chk("R2 readback", d, {16'h0, exp_prot});
  endtask

  task automatic t_no_clear();
    logic [31:0] d; logic w; logic [BE_W-1:0] b;
    cfg_write(1'b0, 32'h0000_0000);
    rd_reg(1'b0, d); chk("R3 zero write keeps bits", d, {16'h0, exp_prot});
    cfg_write(1'b0, 32'h0000_0041);
    exp_prot |= 16'h0041;
    rd_reg(1'b0, d); chk("R3 OR accumulate", d, {16'h0, exp_prot});
    mem_write(2, w, b);
    chk("R3 page 2 still locked", {31'h0, w}, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    cfg_write(1'b0, 32'hFFFF_0000);
    rd_reg(1'b0, d); chk("R4 prot upper bits zero", d, {16'h0, exp_prot});
    clear_flag();
    cfg_write(1'b1, 32'hFFFF_FFFE);
    rd_reg(1'b1, d); chk("R4 status upper bits zero", d, 32'h0);
  endtask

  task automatic t_unimpl();
    logic [31:0] d; logic w; logic [BE_W-1:0] b;
    cfg_write(1'b0, 32'h0000_FF00);
    rd_reg(1'b0, d); chk("R5 unimplemented bits read zero", d, {16'h0, exp_prot});
    mem_write(12, w, b);
    chk("R5 page above count not blocked", {31'h0, w}, 32'h1);
    chk("R5 no violation", {31'h0, wp_violation}, 32'h0);
  endtask

  task automatic t_reads();
    @(negedge clk);
    mem_addr = paddr(0, 40); mem_re = 1'b1; mem_we = 1'b0;
    #1;
    chk("R7 read enable passes on locked page", {31'h0, sram_re}, 32'h1);
    chk("R7 address passes", {18'h0, sram_addr}, {18'h0, paddr(0, 40)});
    @(negedge clk);
    mem_re = 1'b0;
    chk("R7 read raises no violation", {31'h0, wp_violation}, 32'h0);
  endtask

  task automatic t_viol();
    logic w; logic [BE_W-1:0] b; logic [31:0] d;
    mem_write(6, w, b);
    chk("R8 flag set after blocked write", {31'h0, wp_violation}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R8 flag sticky", {31'h0, wp_violation}, 32'h1);
    cfg_write(1'b1, 32'h0);
    rd_reg(1'b1, d); chk("R9 zero write keeps flag", d, 32'h1);
    clear_flag();
    chk("R9 one write clears flag", {31'h0, wp_violation}, 32'h0);
    // clear and blocked write in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h1;
    mem_addr = paddr(0, 4); mem_we = 1'b1; mem_be = 4'hF;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0; mem_we = 1'b0; mem_be = '0;
    chk("R9 set wins over clear", {31'h0, wp_violation}, 32'h1);
  endtask

  task automatic t_reset_clears();
    logic [31:0] d; logic w; logic [BE_W-1:0] b;
    do_reset();
    rd_reg(1'b0, d); chk("R10 reset clears prot", d, 32'h0);
    chk("R10 reset clears flag", {31'h0, wp_violation}, 32'h0);
    mem_write(2, w, b);
    chk("R10 page 2 writable again", {31'h0, w}, 32'h1);
  endtask

  initial begin
    #(4 * 20000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_timing();
    t_no_clear();
    t_reserved();
    t_unimpl();
    t_reads();
    t_viol();
    t_reset_clears();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule